// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives characters on a two-wire synchronous link on which it drives the serial clock. A programmable divider sets the length of each clock half-period. The block samples the incoming data line once per clock cycle and assembles the samples into a character of eight bits, or nine bits when the wide mode is selected. Each finished character goes to a downstream receive buffer through a one-cycle push strobe. The buffer itself lives outside this block.

Two enables start reception. The single-shot enable is a request that the block holds internally. It produces exactly one character and then clears itself. The continuous enable is a level input, and the clock keeps running for as long as that level stays high. If reception stops partway through a character, the clock drops at once and the partial character is discarded. The block will not start a new character while the downstream buffer flags an overrun. Dropping the port enable returns the whole block to idle.

Top module: `sync_master_rx`

## Requirements
- R1: A pulse on `single_set` with `cont_en` low makes the block produce exactly as many rising edges on `sclk` as the character has bits, push one character, and clear the single-shot request, so no further clock edges follow.
- R2: While `cont_en` stays high, characters follow back to back. The low time between the last falling edge of one character and the first rising edge of the next equals one half-period.
- R3: When `cont_en` falls and no single-shot request is pending, `sclk` is low in the next cycle and the partial character is never pushed.
- R4: When both enables are set, the single-shot request clears when the first character completes, and from then on only `cont_en` keeps reception running.
- R5: The data line is sampled on each falling edge of `sclk`, least significant bit first. `push_data[i]` holds the sample taken at the (i+1)-th falling edge of the character, and `push_data[8]` is 0 in 8-bit mode.
- R6: If `nine_bit` is high when a character starts, that character takes 9 clock cycles and its ninth sample appears in `push_data[8]`.
- R7: `sclk` is low out of reset and whenever no character is in progress. Each high phase and each low phase within a character lasts `baud_div`+1 cycles of `clk`.
- R8: `push` is a one-cycle pulse, asserted in the cycle in which `sclk` falls for the final bit of a character.
- R9: While `ovr_in` is high, no new character starts. A character already in progress still completes and is pushed.
- R10: While `port_en` is low, `sclk` is forced low from the next cycle, any partial character is dropped, and the single-shot request is cleared, so re-enabling the port does not resume reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Port enable; low holds the block idle |
| nine_bit | input | 1 | Selects 9-bit characters, taken at character start |
| single_set | input | 1 | One-cycle request for a single character |
| cont_en | input | 1 | Level enable for continuous reception |
| ovr_in | input | 1 | Downstream buffer overrun; blocks new characters |
| baud_div | input | DIV_W | Half-period length minus one, in `clk` cycles |
| sdata | input | 1 | Serial data line |
| sclk | output | 1 | Generated serial clock, idles low |
| push | output | 1 | One-cycle strobe carrying a finished character |
| push_data | output | DATA_W+1 | Received character; the top bit is the ninth bit |

## Verification
Four properties are checked on every cycle: `push` falls only together with `sclk`, a disabled port holds the clock low, an abort drives the clock low in the next cycle, and an overrun keeps the idle controller idle. The bit counter and the single-shot clear are also checked on every cycle. Other behaviour can only be shown by the bench's scenarios. These are the assembled bit order and ninth-bit placement, the exact edge counts per character, the half-period length for each divider value, and the back-to-back spacing in continuous mode. The bench scenarios also show that a completed single shot does not restart, that an overrun raised mid-character lets that character finish, and that re-enabling the port does not resume reception.

// File: rtl/smr_pkg.sv
package smr_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } smr_state_e;
endpackage

// File: rtl/smr_baud.sv
module smr_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/smr_ctrl.sv
module smr_ctrl
   import smr_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 4,
   parameter bit NINTH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             port_en,
   input  logic             nine_bit,
   input  logic             single_set,
   input  logic             cont_en,
   input  logic             ovr,
   input  logic             tick,
   output logic             sclk_o,
   output logic             run_o,
   output logic             start_o,
   output logic             sample_o,
   output logic             last_o,
   output logic [CNT_W-1:0] bit_idx_o,
   output logic             nine_o
);
   localparam logic [CNT_W-1:0] NB_BASE = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] NB_EXT  = CNT_W'(DATA_W + 1);

   smr_state_e       state_q;
   logic             sclk_q, single_q, nine_q;
   logic [CNT_W-1:0] bitcnt_q, nbits;
   logic             want, chr_done, begin_chr;

   assign want      = cont_en | single_q;
   assign nbits     = nine_q ? NB_EXT : NB_BASE;
   assign chr_done  = (bitcnt_q == nbits);
   assign begin_chr = want && !ovr &&
                      ((state_q == ST_IDLE) ||
                       ((state_q == ST_RUN) && tick && !sclk_q && chr_done));
   assign sample_o  = (state_q == ST_RUN) && want && tick && sclk_q;
   assign last_o    = (bitcnt_q == nbits - 1'b1);
   assign start_o   = begin_chr;
   assign sclk_o    = sclk_q;
   assign run_o     = (state_q == ST_RUN);
   assign bit_idx_o = bitcnt_q;
   assign nine_o    = nine_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         sclk_q   <= 1'b0;
         bitcnt_q <= '0;
         nine_q   <= 1'b0;
      end else if (!port_en) begin
         state_q  <= ST_IDLE;
         sclk_q   <= 1'b0;
         bitcnt_q <= '0;
         nine_q   <= 1'b0;
      end else if (begin_chr) begin
         state_q  <= ST_RUN;
         sclk_q   <= 1'b1;
         bitcnt_q <= '0;
         nine_q   <= NINTH_EN & nine_bit;
      end else if (state_q == ST_RUN) begin
         if (!want) begin
            state_q  <= ST_IDLE;
            sclk_q   <= 1'b0;
            bitcnt_q <= '0;
         end else if (tick) begin
            if (sclk_q) begin
               sclk_q   <= 1'b0;
               bitcnt_q <= bitcnt_q + 1'b1;
            end else if (chr_done) begin
               state_q  <= ST_IDLE;
               bitcnt_q <= '0;
            end else begin
               sclk_q <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         single_q <= 1'b0;
      else if (!port_en)
         single_q <= 1'b0;
      else if (single_set)
         single_q <= 1'b1;
      else if (sample_o && last_o)
         single_q <= 1'b0;
   end

   AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && state_q == ST_RUN && !cont_en && !single_q) |=> !sclk_q); // R3
   AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && ovr) |=> (state_q == ST_IDLE && !sclk_q)); // R9
   AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && sample_o && last_o && !single_set) |=> !single_q); // R1
   AST_BITCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt_q <= nbits); // R6
endmodule

// File: rtl/smr_shift.sv
module smr_shift #(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 4,
   parameter bit NINTH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              start,
   input  logic              sample,
   input  logic              last,
   input  logic [CNT_W-1:0]  bit_idx,
   input  logic              nine_i,
   input  logic              sdata,
   output logic              push,
   output logic [DATA_W:0]   push_data
);
   logic [DATA_W:0] sh_q, nxt;
   logic            top_bit;

   always_comb begin
      nxt          = sh_q;
      nxt[bit_idx] = sdata;
   end

   if (NINTH_EN) begin : g_ninth
      assign top_bit = nine_i ? nxt[DATA_W] : 1'b0;
   end else begin : g_plain
      assign top_bit = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q      <= '0;
         push      <= 1'b0;
         push_data <= '0;
      end else if (!port_en) begin
         sh_q      <= '0;
         push      <= 1'b0;
         push_data <= '0;
      end else begin
         push <= 1'b0;
         if (start) begin
            sh_q <= '0;
         end else if (sample) begin
            sh_q <= nxt;
            if (last) begin
               push      <= 1'b1;
               push_data <= {top_bit, nxt[DATA_W-1:0]};
            end
         end
      end
   end
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx #(
   parameter int DATA_W   = 8,
   parameter int DIV_W    = 16,
   parameter bit NINTH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             port_en,
   input  logic             nine_bit,
   input  logic             single_set,
   input  logic             cont_en,
   input  logic             ovr_in,
   input  logic [DIV_W-1:0] baud_div,
   input  logic             sdata,
   output logic             sclk,
   output logic             push,
   output logic [DATA_W:0]  push_data
);
   localparam int CNT_W = $clog2(DATA_W + 2);

   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
      $error("sync_master_rx: DATA_W out of range");
   end
   if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div
      $error("sync_master_rx: DIV_W out of range");
   end

   logic             tick, run, start, sample, last, nine_q;
   logic [CNT_W-1:0] bit_idx;

   smr_baud #(.DIV_W(DIV_W)) u_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (baud_div),
      .tick (tick)
   );

   smr_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NINTH_EN(NINTH_EN)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_en   (port_en),
      .nine_bit  (nine_bit),
      .single_set(single_set),
      .cont_en   (cont_en),
      .ovr       (ovr_in),
      .tick      (tick),
      .sclk_o    (sclk),
      .run_o     (run),
      .start_o   (start),
      .sample_o  (sample),
      .last_o    (last),
      .bit_idx_o (bit_idx),
      .nine_o    (nine_q)
   );

   smr_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NINTH_EN(NINTH_EN)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .port_en  (port_en),
      .start    (start),
      .sample   (sample),
      .last     (last),
      .bit_idx  (bit_idx),
      .nine_i   (nine_q),
      .sdata    (sdata),
      .push     (push),
      .push_data(push_data)
   );

   AST_PUSH_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!sclk && $past(sclk))); // R8
   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> (!sclk && !push)); // R10
endmodule

// File: tb/sim_sync_master_rx.sv
module sim_sync_master_rx;
   localparam int CLK_PER = 10;

   logic        clk = 1'b0, rst_n = 1'b0, port_en = 1'b0, nine_bit = 1'b0;
   logic        single_set = 1'b0, cont_en = 1'b0, ovr_in = 1'b0, sdata = 1'b0;
   logic [15:0] baud_div = '0;
   logic        sclk, push;
   logic [8:0]  push_data;

   int n_chk = 0, n_fail = 0;
   int rises = 0, push_cnt = 0, hi_len = 0, lo_len = 0;
   int bi = 0, wk = 0, seed = 0, nb = 8;
   bit width_chk = 1'b0, gap_chk = 1'b0, prev_sclk = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   sync_master_rx u0 (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .nine_bit(nine_bit),
      .single_set(single_set), .cont_en(cont_en), .ovr_in(ovr_in),
      .baud_div(baud_div), .sdata(sdata), .sclk(sclk), .push(push),
      .push_data(push_data)
   );

   function automatic logic [8:0] wfn(int k);
      int v;
      v = k * 73 + seed * 41 + 29;
      return (nb == 9) ? v[8:0] : {1'b0, v[7:0]};
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic clr();
      rises = 0; push_cnt = 0; bi = 0; wk = 0;
   endtask

   task automatic wait_push(int n, int cap);
      for (int c = 0; c < cap && push_cnt < n; c++) step(1);
   endtask

   task automatic wait_rises(int n, int cap);
      for (int c = 0; c < cap && rises < n; c++) step(1);
   endtask

   // serial source: new bit on each leading (rising) edge
   always @(posedge sclk) begin
      logic [8:0] w;
      w = wfn(wk);
      sdata = w[bi];
      bi++;
      if (bi == nb) begin
         bi = 0;
         wk++;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (sclk && !prev_sclk) begin
            rises++;
            if (gap_chk && rises > 1)
               check(lo_len == int'(baud_div) + 1, "R2", lo_len, int'(baud_div) + 1);
            hi_len = 0;
         end
         if (!sclk && prev_sclk) begin
            if (width_chk)
               check(hi_len == int'(baud_div) + 1, "R7", hi_len, int'(baud_div) + 1);
            lo_len = 0;
         end
         if (sclk) hi_len++; else lo_len++;
         if (push) begin
            check(push_data == wfn(push_cnt), (nb == 9) ? "R6" : "R5",
                  int'(push_data), int'(wfn(push_cnt)));
            check(!sclk && prev_sclk, "R8", int'(sclk), 0);
            push_cnt++;
         end
      end
      prev_sclk = sclk;
   end

   initial begin
      #(CLK_PER * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      step(3);
      check(sclk == 1'b0, "R7", int'(sclk), 0);
      check(push == 1'b0, "R8", int'(push), 0);
      rst_n = 1'b1;
      port_en = 1'b1;
      step(6);
      check(sclk == 1'b0 && rises == 0, "R7", rises, 0);

      // R1 R5 R6 R7: single characters over dividers and widths
      width_chk = 1'b1;
      for (int d = 0; d < 4; d++) begin
         for (int nn = 0; nn < 2; nn++) begin
            for (int s = 0; s < 3; s++) begin
               baud_div = 16'(d);
               nine_bit = nn[0];
               nb = nn ? 9 : 8;
               seed = d * 7 + nn * 3 + s;
               clr();
               single_set = 1'b1;
               step(1);
               single_set = 1'b0;
               step(2 * nb * (d + 1) + 8);
               check(rises == nb, "R1", rises, nb);
               check(push_cnt == 1, "R1", push_cnt, 1);
               step(30);
               check(rises == nb, "R1", rises, nb);
            end
         end
      end

      // R2 R3: continuous run, stopped at a boundary
      baud_div = 16'd1; nine_bit = 1'b0; nb = 8; seed = 50; clr();
      gap_chk = 1'b1;
      cont_en = 1'b1;
      wait_push(5, 400);
      check(push_cnt == 5, "R2", push_cnt, 5);
      check(rises == 40, "R2", rises, 40);
      cont_en = 1'b0;
      step(1);
      check(sclk == 1'b0, "R3", int'(sclk), 0);
      step(40);
      check(push_cnt == 5, "R3", push_cnt, 5);
      gap_chk = 1'b0;

      // R3: continuous enable dropped mid character
      baud_div = 16'd2; seed = 60; clr();
      width_chk = 1'b0;
      cont_en = 1'b1;
      wait_rises(3, 200);
      cont_en = 1'b0;
      step(1);
      check(sclk == 1'b0, "R3", int'(sclk), 0);
      step(50);
      check(push_cnt == 0, "R3", push_cnt, 0);
      check(rises == 3, "R3", rises, 3);

      // R4: both enables, single clears after first character
      baud_div = 16'd0; nine_bit = 1'b1; nb = 9; seed = 70; clr();
      width_chk = 1'b1;
      gap_chk = 1'b1;
      cont_en = 1'b1;
      single_set = 1'b1;
      step(1);
      single_set = 1'b0;
      wait_push(2, 300);
      cont_en = 1'b0;
      step(40);
      check(push_cnt == 2, "R4", push_cnt, 2);
      check(sclk == 1'b0, "R4", int'(sclk), 0);
      gap_chk = 1'b0;

      // R9: overrun blocks new characters only
      baud_div = 16'd0; nine_bit = 1'b0; nb = 8; seed = 80; clr();
      ovr_in = 1'b1;
      cont_en = 1'b1;
      step(40);
      check(rises == 0, "R9", rises, 0);
      ovr_in = 1'b0;
      wait_rises(nb + 2, 300);
      ovr_in = 1'b1;
      step(80);
      check(push_cnt == 2, "R9", push_cnt, 2);
      check(rises == 2 * nb, "R9", rises, 2 * nb);
      cont_en = 1'b0;
      ovr_in = 1'b0;
      step(5);

      // R10: port disable mid character
      baud_div = 16'd3; seed = 90; clr();
      width_chk = 1'b0;
      single_set = 1'b1;
      step(1);
      single_set = 1'b0;
      wait_rises(4, 300);
      port_en = 1'b0;
      step(1);
      check(sclk == 1'b0, "R10", int'(sclk), 0);
      check(push == 1'b0, "R10", int'(push), 0);
      step(2);
      port_en = 1'b1;
      step(100);
      check(push_cnt == 0, "R10", push_cnt, 0);
      check(rises == 4, "R10", rises, 4);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule